// File: doc/BRIEF.md
# DS3 Serial Payload Source

This block sits on the terminal-equipment side of a DS3 framer and feeds it payload bits one at a time. It runs on the bit-rate clock that the framer supplies. It updates its serial output on each rising edge of that clock. It takes bytes from a valid/ready byte stream and keeps one byte in a holding register. It shifts that byte out most-significant bit first.

The framer steers the serializer with two pulses. An overhead warning tells the block to skip the next clock edge, because the framer inserts an overhead bit there. The block then holds its output for exactly one period and resumes with the bit it was about to send. An end-of-frame pulse marks the last bit of a frame. On the next payload slot the block starts a new frame on a byte boundary.

After reset the block is unaligned and drives 0. The first end-of-frame pulse aligns it, and it reports this on a status flag. If no byte is held when a payload bit is due, the block sends a 1 and raises a sticky underrun flag.

Top module: `ds3_payload_src`

## Requirements
- R1: While reset is asserted, and right after it, `ser_data`, `aligned` and `underrun` are 0 and `byte_ready` is 1.
- R2: Until the first `eof_pulse` is sampled, `ser_data` stays 0 and no payload bit is consumed.
- R3: The clock edge that samples `eof_pulse` high sets `aligned`. It stays set until reset.
- R4: A payload slot is an edge at which the block is aligned (or becomes aligned) and `oh_warn` is low. At each payload slot `ser_data` takes the next bit of the held byte. A byte (`DATA_W` = 8 bits by default) goes out most-significant bit first, bit 7 down to bit 0.
- R5: An edge that samples `oh_warn` high while aligned is not a payload slot. `ser_data` keeps its value, and the pending bit goes out at the next payload slot.
- R6: At the first payload slot at or after an `eof_pulse`, a new frame starts. The held byte is sent from its most-significant bit, and a byte that was only partly sent is re-sent whole.
- R7: If `oh_warn` and `eof_pulse` are sampled high at the same edge, the stall applies at that edge and the frame restart happens at the following payload slot.
- R8: A payload slot with no byte held sends a 1 and sets `underrun`. `underrun` stays set until an edge samples `under_clr` high with no new underrun, and a new underrun wins over the clear.
- R9: `byte_ready` is high exactly when the holding register is empty, or when its last bit goes out at a payload slot that does not restart the frame. A byte is taken at an edge where `byte_valid` and `byte_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock supplied by the framer |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_data | input | DATA_W | Payload byte offered by the upstream source |
| byte_valid | input | 1 | `byte_data` is valid |
| byte_ready | output | 1 | The block takes the byte at this edge |
| eof_pulse | input | 1 | Framer end-of-frame pulse, one bit period long |
| oh_warn | input | 1 | Framer warning that the next edge is an overhead slot |
| under_clr | input | 1 | Clears the sticky underrun flag |
| ser_data | output | 1 | Serial payload bit to the framer |
| aligned | output | 1 | Frame alignment has been reached |
| underrun | output | 1 | Sticky flag: a payload bit was due with no byte held |

## Verification
The serializer is first driven with a steady byte stream and no overhead, which shows that bits go out most-significant first across byte boundaries. It is then driven with isolated and back-to-back overhead warnings. These separate a true one-cycle hold from a dropped or repeated bit. End-of-frame pulses placed in the middle of a byte, and placed together with an overhead warning, show whether the restart re-sends the byte from its top bit and whether it waits for the next payload slot. Stretches with no valid bytes, with clear pulses mixed in, test the difference between underrun fill and real data, and test the priority of setting the flag over clearing it.

// File: rtl/ds3ps_pkg.sv
package ds3ps_pkg;
  // Per-edge decision of the slot controller
  typedef struct packed {
    logic slot;     // this edge presents a payload bit
    logic restart;  // this payload slot opens a new frame
  } slot_ctl_t;
endpackage

// File: rtl/ds3ps_slot_ctrl.sv
module ds3ps_slot_ctrl
  import ds3ps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      eof_pulse,
  input  logic      oh_warn,
  output slot_ctl_t ctl,
  output logic      aligned_q
);
  logic aligned_d;
  logic pend_q, pend_d;

  always_comb begin
    aligned_d   = aligned_q | eof_pulse;
    ctl.slot    = aligned_d & ~oh_warn;
    ctl.restart = ctl.slot & (eof_pulse | pend_q);
    pend_d      = (pend_q | eof_pulse) & ~ctl.slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      aligned_q <= aligned_d;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/ds3ps_hold.sv
module ds3ps_hold
  import ds3ps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ctl_t         ctl,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  output logic              cur_bit,
  output logic              full
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] TOP = IW'(DATA_W - 1);

  logic [DATA_W-1:0] byte_q, byte_d;
  logic              full_q, full_d;
  logic [IW-1:0]     idx_q, idx_d, cur_idx;
  logic              last, take, en;

  always_comb begin
    cur_idx    = ctl.restart ? TOP : idx_q;
    cur_bit    = byte_q[cur_idx];
    last       = ctl.slot & full_q & (cur_idx == '0);
    byte_ready = ~full_q | last;
    take       = byte_valid & byte_ready;
    en         = take | (ctl.slot & full_q);
    byte_d     = byte_q;
    full_d     = full_q;
    idx_d      = idx_q;
    if (take) begin
      byte_d = byte_data;
      full_d = 1'b1;
      idx_d  = TOP;
    end else if (last) begin
      full_d = 1'b0;
    end else if (ctl.slot && full_q) begin
      idx_d = cur_idx - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      full_q <= 1'b0;
      idx_q  <= TOP;
    end else if (en) begin
      byte_q <= byte_d;
      full_q <= full_d;
      idx_q  <= idx_d;
    end
  end

  assign full = full_q;
endmodule

// File: rtl/ds3_payload_src.sv
module ds3_payload_src
  import ds3ps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              eof_pulse,
  input  logic              oh_warn,
  input  logic              under_clr,
  output logic              ser_data,
  output logic              aligned,
  output logic              underrun
);
  slot_ctl_t ctl;
  logic      cur_bit, full;
  logic      ser_q, ser_d, und_q, und_d;

  ds3ps_slot_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .eof_pulse (eof_pulse),
    .oh_warn   (oh_warn),
    .ctl       (ctl),
    .aligned_q (aligned)
  );

  ds3ps_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .cur_bit    (cur_bit),
    .full       (full)
  );

  always_comb begin
    ser_d = ser_q;
    if (ctl.slot) ser_d = full ? cur_bit : 1'b1;
    und_d = (ctl.slot & ~full) | (und_q & ~under_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      ser_q <= ser_d;
      und_q <= und_d;
    end
  end

  assign ser_data = ser_q;
  assign underrun = und_q;
endmodule

// File: rtl/ds3_payload_src_chk.sv
module ds3_payload_src_chk (
  input logic clk,
  input logic rst_n,
  input logic eof_pulse,
  input logic oh_warn,
  input logic under_clr,
  input logic ser_data,
  input logic aligned,
  input logic underrun
);
  p_quiet_unaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !ser_data);
  p_no_underrun_unaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !underrun);
  p_align_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |=> aligned);
  p_align_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |=> aligned);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && oh_warn) |=> $stable(ser_data));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !under_clr) |=> underrun);
  p_under_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ser_data);
endmodule

bind ds3_payload_src ds3_payload_src_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eof_pulse (eof_pulse),
  .oh_warn   (oh_warn),
  .under_clr (under_clr),
  .ser_data  (ser_data),
  .aligned   (aligned),
  .underrun  (underrun)
);

// File: tb/ds3_payload_src_bench.sv
`timescale 1ns/1ps
module ds3_payload_src_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] byte_data;
  logic       byte_valid, byte_ready, eof_pulse, oh_warn, under_clr;
  logic       ser_data, aligned, underrun;

  always #2.5 clk = ~clk;

  ds3_payload_src #(.DATA_W(8)) u_ds3_payload_src (
    .clk(clk), .rst_n(rst_n), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .eof_pulse(eof_pulse), .oh_warn(oh_warn),
    .under_clr(under_clr), .ser_data(ser_data), .aligned(aligned),
    .underrun(underrun)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state, kept from the requirements
  bit       m_al, m_pend, m_full, m_ser, m_und;
  bit [7:0] m_byte;
  int       m_sent;     // bits of the held byte already sent
  string    m_tag;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_slot(bit e, bit o);
    return (m_al || e) && !o;
  endfunction

  function automatic bit exp_ready(bit e, bit o);
    bit s, rs;
    s  = is_slot(e, o);
    rs = s && (e || m_pend);
    return !m_full || (s && !rs && m_sent == 7);
  endfunction

  task automatic model_step(bit v, bit [7:0] d, bit e, bit o, bit c);
    bit s, rs, rdy, und_set;
    s   = is_slot(e, o);
    rs  = s && (e || m_pend);
    rdy = exp_ready(e, o);
    und_set = 0;
    if (!(m_al || e))      m_tag = "R2";
    else if (!s)           m_tag = "R5";
    else if (rs && m_pend) m_tag = "R7";
    else if (rs)           m_tag = "R6";
    else                   m_tag = "R4";
    if (s) begin
      if (rs) m_sent = 0;
      if (m_full) begin
        m_ser = m_byte[7 - m_sent];
        m_sent++;
        if (m_sent == 8) m_full = 0;
      end else begin
        m_ser = 1; und_set = 1; m_tag = "R8";
      end
    end
    if (v && rdy) begin
      m_byte = d; m_full = 1; m_sent = 0;
    end
    m_und  = und_set || (m_und && !c);
    m_pend = (m_pend || e) && !s;
    m_al   = m_al || e;
  endtask

  // one clock: check last edge's outputs, drive, check ready, advance model
  task automatic cyc(bit v, bit [7:0] d, bit e, bit o, bit c);
    @(negedge clk);
    chk(ser_data == m_ser, m_tag, ser_data, m_ser);
    chk(aligned == m_al, "R3", aligned, m_al);
    chk(underrun == m_und, "R8", underrun, m_und);
    byte_valid = v; byte_data = d; eof_pulse = e; oh_warn = o; under_clr = c;
    #1;
    chk(byte_ready == exp_ready(e, o), "R9", byte_ready, exp_ready(e, o));
    model_step(v, d, e, o, c);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    int gap;
    seed = 32'h5eed_d53;
    void'($urandom(seed));
    rst_n = 0; byte_valid = 0; byte_data = 0; eof_pulse = 0; oh_warn = 0; under_clr = 0;
    m_al = 0; m_pend = 0; m_full = 0; m_ser = 0; m_und = 0; m_byte = 0; m_sent = 0; m_tag = "R2";
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ser_data == 0, "R1", ser_data, 0);
    chk(aligned == 0, "R1", aligned, 0);
    chk(underrun == 0, "R1", underrun, 0);
    chk(byte_ready == 1, "R1", byte_ready, 1);
    rst_n = 1;
    // R2: data offered but no frame pulse yet
    for (int i = 0; i < 10; i++) cyc(1, 8'hA5, 0, 0, 0);
    // R7: frame pulse together with an overhead warning
    cyc(1, 8'h3C, 1, 1, 0);
    for (int i = 0; i < 12; i++) cyc(1, 8'hC3 ^ 8'(i), 0, 0, 0);
    // R6: frame pulse in the middle of a byte
    cyc(1, 8'h00, 0, 0, 0);
    cyc(1, 8'h00, 0, 0, 0);
    cyc(1, 8'h00, 1, 0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 8'h96, 0, 0, 0);
    // R5: back-to-back and isolated overhead warnings
    cyc(1, 8'h5A, 0, 1, 0);
    cyc(1, 8'h5A, 0, 1, 0);
    cyc(1, 8'h5A, 0, 0, 0);
    cyc(1, 8'h5A, 0, 1, 0);
    for (int i = 0; i < 10; i++) cyc(1, 8'h71, 0, 0, 0);
    // R8: starve, clear during starvation, then clear after refill
    for (int i = 0; i < 20; i++) cyc(0, 8'h00, 0, 0, (i == 15));
    cyc(1, 8'hF0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 8'h0F, 0, 0, (i == 2));
    // random mix
    gap = 30;
    for (int i = 0; i < 4000; i++) begin
      bit e;
      gap--;
      e = (gap <= 0);
      if (e) gap = 20 + int'($urandom_range(40));
      cyc(($urandom_range(7) != 0) && !((i / 300) % 5 == 4), 8'($urandom),
          e, ($urandom_range(7) == 0), ($urandom_range(31) == 0));
    end
    @(negedge clk);
    chk(ser_data == m_ser, m_tag, ser_data, m_ser);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule